// File: doc/BRIEF.md
# Framed and Synchronous Serial Transmitter

This block serialises words onto a single output line. The host writes words into a one-word holding buffer. The block moves each word into an output shifter and sends it least significant bit first. Two line formats are supported. The framed format wraps each word in a low start bit and a high stop bit. The synchronous format sends the bare data bits. The line only moves on cycles where the bit-rate enable input is high, so the surrounding chip decides the baud rate.

When the host falls behind, the block fills the line on its own. In framed format it holds the line high. In synchronous format it repeats a programmable sync word until a new word arrives. It can also send a break, which is an all-zero character repeated for as long as break is requested. It pulses an error interrupt at every character boundary of a break, so software can time the break. Enabling and disabling follow strict rules about what happens to the buffered word and to the status flags. One interrupt line reports that the buffer has become free. A second line reports underrun, the end of transmission and break boundaries.

The host interface is a simple write port with four word addresses:
- Address 0 loads the buffer.
- Address 1 is control. Bit 0 is enable, bit 1 selects synchronous format, bit 2 requests a break.
- Address 2 holds the sync word.
- Address 3 clears status. Writing 1 in bit 0 clears underrun.

Top module: `sertx_core`

## Requirements
- R1: After reset the line is high, the buffer-free flag is 1, the underrun and stopped flags are 0, and both interrupt outputs are low.
- R2: A word is sent on consecutive bit ticks, one bit per tick. In framed format the sequence is a 0 start bit, then the data bits LSB first, then a 1 stop bit, for 10 ticks. In synchronous format it is the 8 data bits LSB first.
- R3: The line changes only in the cycle after a rising clock edge at which the bit-rate enable was high.
- R4: When the transmitter is enabled from the stopped state, exactly one bit time of 1 is sent before the first word or fill.
- R5: A word written to address 0 while the transmitter is disabled is held. The buffer-free flag stays 0 and the line stays high until enable. After enable the word is the first one sent.
- R6: The buffer-free flag rises when the buffered word moves into the shifter. irq_empty is a one-cycle pulse on each rise of that flag and at no other time.
- R7: At a character boundary, the underrun flag is set if all of these hold: the transmitter is enabled, no break is requested, the buffer is empty, and the character just finished was a data word. Each rise of the flag pulses irq_err. Writing 1 to bit 0 of address 3 clears the flag. If a set and a clear fall in the same cycle, the set wins.
- R8: While no word is available, framed format holds the line at 1. Synchronous format sends the sync word (address 2) repeatedly, LSB first, and a new word follows once the current sync word completes.
- R9: When enable is cleared, the character in progress completes. A buffered word is not sent and stays buffered, the buffer-free flag stays 0 and irq_empty does not pulse. That word is sent after the next enable.
- R10: If enable is cleared with a character in progress and an empty buffer, no underrun is raised when that character completes.
- R11: When the transmitter stops after being disabled, the stopped flag is set and irq_err pulses. A control write with enable set clears the stopped flag.
- R12: While break is requested, each character slot is all zeros with the length of a normal character. irq_err pulses at the start of every such slot, and the underrun and buffer-free flags are unchanged.
- R13: If enable is cleared during a break, the zero level lasts until the end of the current break slot. At that boundary the line goes high at once and the stopped flag is set, with no extra stop-bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate enable, one cycle per bit time |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address |
| wr_data | input | DATA_W | Host write data |
| tx_line | output | 1 | Serial data output |
| irq_empty | output | 1 | Buffer-free interrupt pulse |
| irq_err | output | 1 | Underrun, stopped and break-boundary interrupt pulse |
| sts_empty | output | 1 | Buffer-free flag |
| sts_underrun | output | 1 | Underrun flag |
| sts_end | output | 1 | Stopped flag |

## Verification
An underrun can be detected at a bit tick in the same cycle that the host writes the underrun clear. Both then act on the same flag register. The bench provokes this by raising the bit-rate enable and the clear write together on the exact tick that ends a synchronous data word with the buffer empty. It judges the outcome by checking, in the following cycle, that the underrun flag reads 1, that irq_err pulses, and that the first sync-word bit is on the line.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   // Kind of character slot chosen at each boundary
   typedef enum logic [2:0] {
      SL_OFF,
      SL_LEAD,
      SL_WORD,
      SL_FILL,
      SL_BRK
   } slot_e;

   // Host register addresses
   localparam logic [1:0] A_DATA = 2'd0;
   localparam logic [1:0] A_CTRL = 2'd1;
   localparam logic [1:0] A_SYNC = 2'd2;
   localparam logic [1:0] A_STAT = 2'd3;

   // Control bit positions
   localparam int C_EN   = 0;
   localparam int C_SYNC = 1;
   localparam int C_BRK  = 2;

endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
   import sertx_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          load,
   input  logic          urun_set,
   input  logic          end_set,
   output logic          en,
   output logic          sync_md,
   output logic          brk,
   output logic [DW-1:0] sync_chr,
   output logic [DW-1:0] buf_q,
   output logic          buf_full,
   output logic          urun,
   output logic          end_flg
);

   logic wr_ctrl, wr_dat, wr_syn, wr_clr;

   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
   assign wr_dat  = wr_en && (wr_addr == A_DATA);
   assign wr_syn  = wr_en && (wr_addr == A_SYNC);
   assign wr_clr  = wr_en && (wr_addr == A_STAT) && wr_data[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en       <= 1'b0;
         sync_md  <= 1'b0;
         brk      <= 1'b0;
         sync_chr <= '0;
         buf_q    <= '0;
         buf_full <= 1'b0;
         urun     <= 1'b0;
         end_flg  <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            en      <= wr_data[C_EN];
            sync_md <= wr_data[C_SYNC];
            brk     <= wr_data[C_BRK];
         end
         if (wr_syn) sync_chr <= wr_data;
         // a host write wins over a simultaneous hand-off to the shifter
         if (wr_dat) begin
            buf_q    <= wr_data;
            buf_full <= 1'b1;
         end else if (load) begin
            buf_full <= 1'b0;
         end
         // set wins over clear for the underrun flag
         if (wr_clr)   urun <= 1'b0;
         if (urun_set) urun <= 1'b1;
         // enabling clears the stopped flag
         if (end_set)                        end_flg <= 1'b1;
         if (wr_ctrl && wr_data[C_EN])       end_flg <= 1'b0;
      end
   end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          en,
   input  logic          sync_md,
   input  logic          brk,
   input  logic          buf_full,
   input  logic [DW-1:0] buf_q,
   input  logic [DW-1:0] sync_chr,
   output logic          line,
   output logic          load,
   output logic          urun_set,
   output logic          brk_pulse,
   output logic          end_set
);

   localparam int FW = DW + 2;
   localparam int CW = $clog2(FW + 1);
   localparam logic [CW-1:0] LEN_S = CW'(DW);
   localparam logic [CW-1:0] LEN_A = CW'(FW);
   localparam logic [CW-1:0] LEN_1 = CW'(1);

   logic [FW-1:0] sh;
   logic [CW-1:0] cnt;
   logic          running;
   logic          last_word;
   logic          edge_now;
   slot_e         kind;
   logic [FW-1:0] frm;
   logic [CW-1:0] flen;

   assign edge_now = tick && (cnt == '0);

   // choose the next slot
   always_comb begin
      if (!running)      kind = en ? SL_LEAD : SL_OFF;
      else if (!en)      kind = SL_OFF;
      else if (brk)      kind = SL_BRK;
      else if (buf_full) kind = SL_WORD;
      else               kind = SL_FILL;
   end

   // bit pattern and length of that slot
   always_comb begin
      frm  = '1;
      flen = LEN_1;
      unique case (kind)
         SL_WORD: begin
            if (sync_md) begin
               frm  = {2'b11, buf_q};
               flen = LEN_S;
            end else begin
               frm  = {1'b1, buf_q, 1'b0};
               flen = LEN_A;
            end
         end
         SL_FILL: begin
            if (sync_md) begin
               frm  = {2'b11, sync_chr};
               flen = LEN_S;
            end
         end
         SL_BRK: begin
            frm  = '0;
            flen = sync_md ? LEN_S : LEN_A;
         end
         default: ;
      endcase
   end

   assign load      = edge_now && (kind == SL_WORD);
   assign urun_set  = edge_now && (kind == SL_FILL) && last_word;
   assign brk_pulse = edge_now && (kind == SL_BRK);
   assign end_set   = edge_now && running && (kind == SL_OFF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh        <= '1;
         cnt       <= '0;
         running   <= 1'b0;
         last_word <= 1'b0;
         line      <= 1'b1;
      end else if (tick) begin
         if (cnt == '0) begin
            line      <= frm[0];
            sh        <= frm >> 1;
            cnt       <= flen - LEN_1;
            running   <= (kind != SL_OFF);
            last_word <= (kind == SL_WORD);
         end else begin
            line <= sh[0];
            sh   <= sh >> 1;
            cnt  <= cnt - LEN_1;
         end
      end
   end

endmodule

// File: rtl/sertx_irq.sv
module sertx_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic empty,
   input  logic urun,
   input  logic end_flg,
   input  logic brk_pulse,
   output logic irq_empty,
   output logic irq_err
);

   logic empty_q, urun_q, end_q, brk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         urun_q  <= 1'b0;
         end_q   <= 1'b0;
         brk_q   <= 1'b0;
      end else begin
         empty_q <= empty;
         urun_q  <= urun;
         end_q   <= end_flg;
         brk_q   <= brk_pulse;
      end
   end

   assign irq_empty = empty & ~empty_q;
   assign irq_err   = (urun & ~urun_q) | (end_flg & ~end_q) | brk_q;

endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              tx_line,
   output logic              irq_empty,
   output logic              irq_err,
   output logic              sts_empty,
   output logic              sts_underrun,
   output logic              sts_end
);

   generate
      if (DATA_W < 3) begin : g_bad_width
         $error("sertx_core: DATA_W must hold the three control bits");
      end
   endgenerate

   logic              en, sync_md, brk, buf_full;
   logic [DATA_W-1:0] sync_chr, buf_q;
   logic              load, urun_set, brk_pulse, end_set;

   sertx_regs #(.DW(DATA_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .load     (load),
      .urun_set (urun_set),
      .end_set  (end_set),
      .en       (en),
      .sync_md  (sync_md),
      .brk      (brk),
      .sync_chr (sync_chr),
      .buf_q    (buf_q),
      .buf_full (buf_full),
      .urun     (sts_underrun),
      .end_flg  (sts_end)
   );

   sertx_shift #(.DW(DATA_W)) shift_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (bit_en),
      .en        (en),
      .sync_md   (sync_md),
      .brk       (brk),
      .buf_full  (buf_full),
      .buf_q     (buf_q),
      .sync_chr  (sync_chr),
      .line      (tx_line),
      .load      (load),
      .urun_set  (urun_set),
      .brk_pulse (brk_pulse),
      .end_set   (end_set)
   );

   assign sts_empty = ~buf_full;

   sertx_irq irq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .empty     (sts_empty),
      .urun      (sts_underrun),
      .end_flg   (sts_end),
      .brk_pulse (brk_pulse),
      .irq_empty (irq_empty),
      .irq_err   (irq_err)
   );

endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_en,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              tx_line,
   input logic              irq_empty,
   input logic              irq_err,
   input logic              sts_empty,
   input logic              sts_underrun,
   input logic              sts_end
);

   assert_line_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_line));

   assert_empty_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_empty |=> !irq_empty);

   assert_empty_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_empty |-> sts_empty);

   assert_urun_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd3 && wr_data[0] && !bit_en) |=> !sts_underrun);

   assert_urun_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_underrun) |-> irq_err);

   assert_urun_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_underrun) |-> $past(bit_en));

   assert_end_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_end) |-> irq_err);

endmodule

bind sertx_core sertx_core_chk #(.DATA_W(DATA_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .bit_en       (bit_en),
   .wr_en        (wr_en),
   .wr_addr      (wr_addr),
   .wr_data      (wr_data),
   .tx_line      (tx_line),
   .irq_empty    (irq_empty),
   .irq_err      (irq_err),
   .sts_empty    (sts_empty),
   .sts_underrun (sts_underrun),
   .sts_end      (sts_end)
);

// File: tb/sertx_core_tb_top.sv
module sertx_core_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       tx_line, irq_empty, irq_err, sts_empty, sts_underrun, sts_end;

   int n_chk = 0;
   int n_fail = 0;
   int gap_max = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sertx_core #(.DATA_W(8)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_en       (bit_en),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .tx_line      (tx_line),
      .irq_empty    (irq_empty),
      .irq_err      (irq_err),
      .sts_empty    (sts_empty),
      .sts_underrun (sts_underrun),
      .sts_end      (sts_end)
   );

   function automatic logic [9:0] exp_frame(input logic sm, input logic [7:0] d);
      return sm ? {2'b11, d} : {1'b1, d, 1'b0};
   endfunction

   function automatic int exp_len(input logic sm);
      return sm ? 8 : 10;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic restart();
      rst_n = 1'b0; bit_en = 1'b0; wr_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // idle gap (line must hold, R3), then one bit tick
   task automatic tick();
      logic held;
      int   g;
      g = (gap_max > 0) ? int'($urandom_range(gap_max, 0)) : 0;
      held = tx_line;
      for (int k = 0; k < g; k++) begin
         @(negedge clk);
         chk("R3 line held", tx_line, held);
      end
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
   endtask

   task automatic tick_wr(input logic [1:0] a, input logic [7:0] d);
      bit_en = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      bit_en = 1'b0; wr_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [9:0] f;
      void'($urandom(32'd4242));

      // ---------------- R1 reset state
      restart();
      chk("R1 line", tx_line, 1);
      chk("R1 empty", sts_empty, 1);
      chk("R1 underrun", sts_underrun, 0);
      chk("R1 end", sts_end, 0);
      chk("R1 irqs", {irq_empty, irq_err}, 0);

      // ---------------- framed: R5 R4 R2 R6 R7 R8
      wr(2'd0, 8'h5A);
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R5 held line", tx_line, 1);
      end
      chk("R5 held flag", sts_empty, 0);
      wr(2'd1, 8'h01);
      tick();
      chk("R4 lead bit", tx_line, 1);
      f = exp_frame(1'b0, 8'h5A);
      for (int i = 0; i < 10; i++) begin
         tick();
         chk("R2 framed bit", tx_line, f[i]);
         chk("R6 irq_empty", irq_empty, (i == 0));
      end
      chk("R6 empty flag", sts_empty, 1);
      tick();
      chk("R7 underrun set", sts_underrun, 1);
      chk("R7 underrun irq", irq_err, 1);
      chk("R8 mark", tx_line, 1);
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R8 mark held", tx_line, 1);
         chk("R7 single pulse", irq_err, 0);
      end
      wr(2'd3, 8'h01);
      chk("R7 cleared", sts_underrun, 0);

      // ---------------- synchronous: R2 R8 R7 (set and clear same cycle)
      restart();
      wr(2'd2, 8'h96);
      wr(2'd0, 8'hC3);
      wr(2'd1, 8'h03);
      tick();
      chk("R4 lead bit sync", tx_line, 1);
      for (int i = 0; i < 8; i++) begin
         tick();
         chk("R2 sync bit", tx_line, (8'hC3 >> i) & 1);
      end
      tick_wr(2'd3, 8'h01);
      chk("R7 set wins", sts_underrun, 1);
      chk("R7 irq with clear", irq_err, 1);
      chk("R8 sync fill bit", tx_line, 0);
      for (int i = 1; i < 8; i++) begin
         if (i == 3) wr(2'd0, 8'h3C);
         tick();
         chk("R8 sync fill bit", tx_line, (8'h96 >> i) & 1);
      end
      for (int i = 0; i < 8; i++) begin
         tick();
         chk("R8 word after fill", tx_line, (8'h3C >> i) & 1);
      end

      // ---------------- disable with full buffer: R9 R11
      restart();
      wr(2'd0, 8'hA5);
      wr(2'd1, 8'h01);
      tick();
      tick();
      f = exp_frame(1'b0, 8'hA5);
      chk("R2 start bit", tx_line, f[0]);
      wr(2'd0, 8'h0F);
      wr(2'd1, 8'h00);
      for (int i = 1; i < 10; i++) begin
         tick();
         chk("R9 completes", tx_line, f[i]);
      end
      tick();
      chk("R11 end flag", sts_end, 1);
      chk("R11 end irq", irq_err, 1);
      chk("R9 no underrun", sts_underrun, 0);
      chk("R9 word kept", sts_empty, 0);
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R9 idle line", tx_line, 1);
         chk("R9 no irq_empty", irq_empty, 0);
      end
      wr(2'd1, 8'h01);
      chk("R11 end cleared", sts_end, 0);
      tick();
      chk("R4 lead again", tx_line, 1);
      f = exp_frame(1'b0, 8'h0F);
      for (int i = 0; i < 10; i++) begin
         tick();
         chk("R9 kept word sent", tx_line, f[i]);
      end

      // ---------------- disable with empty buffer: R10
      restart();
      wr(2'd0, 8'h81);
      wr(2'd1, 8'h01);
      tick();
      tick();
      wr(2'd1, 8'h00);
      chk("R9 empty stays set", sts_empty, 1);
      for (int i = 1; i < 10; i++) tick();
      tick();
      chk("R10 no underrun", sts_underrun, 0);
      chk("R10 stopped", sts_end, 1);
      chk("R10 empty", sts_empty, 1);

      // ---------------- break: R12 R13
      restart();
      wr(2'd1, 8'h01);
      tick();
      tick();
      chk("R8 fill no underrun", sts_underrun, 0);
      wr(2'd1, 8'h05);
      tick();
      chk("R12 break low", tx_line, 0);
      chk("R12 break pulse", irq_err, 1);
      chk("R12 underrun kept", sts_underrun, 0);
      chk("R12 empty kept", sts_empty, 1);
      for (int i = 1; i < 10; i++) begin
         tick();
         chk("R12 break low", tx_line, 0);
         chk("R12 no mid pulse", irq_err, 0);
      end
      tick();
      chk("R12 second slot", irq_err, 1);
      chk("R12 break low", tx_line, 0);
      wr(2'd1, 8'h04);
      for (int i = 1; i < 10; i++) begin
         tick();
         chk("R13 break runs out", tx_line, 0);
      end
      tick();
      chk("R13 line high", tx_line, 1);
      chk("R13 stopped", sts_end, 1);
      tick();
      chk("R13 stays high", tx_line, 1);
      chk("R13 no more pulses", irq_err, 0);

      // ---------------- random words, both formats, random tick gaps: R2 R3 R6
      gap_max = 2;
      for (int n = 0; n < 40; n++) begin
         logic       sm;
         logic [7:0] d;
         sm = 1'($urandom_range(1, 0));
         d  = 8'($urandom);
         restart();
         if (sm) wr(2'd2, 8'($urandom));
         wr(2'd0, d);
         wr(2'd1, {6'd0, sm, 1'b1});
         tick();
         chk("R4 lead random", tx_line, 1);
         f = exp_frame(sm, d);
         for (int i = 0; i < exp_len(sm); i++) begin
            tick();
            chk("R2 random bit", tx_line, f[i]);
            if (i == 0) chk("R6 random irq_empty", irq_empty, 1);
         end
      end
      gap_max = 0;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule